// File: doc/BRIEF.md
# ISA Byte-Lane Steering Bridge

This bridge sits between a 32-bit processor local bus and a set of 8-bit and 16-bit ISA-style peripherals whose 16-bit data bus is wired directly to processor data lines 15:0. For each processor access it decodes the size and the low address bits. It then runs one peripheral I/O or memory cycle with the right card address, byte-lane enables, strobe and data steering.

Some devices want an odd-port byte on the low lane. For these, the bridge accepts a word-sized access at an aligned offset as a special cycle: peripheral address bit 0 is raised, while the byte still travels on D7:D0. Three UART/printer-style port groups use a different stride and only take plain byte cycles. Memory-window accesses go through a fixed address scramble. Any access the bridge cannot map returns an error in one clock and starts no peripheral cycle.

The processor holds `req` with stable controls until it sees `ack` or `err`, which last one clock. It drops `req` before the next edge.

Top module: `isa_lane_bridge`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, all four strobes, `p_ben`, `ack` and `err` are 0.
- R2: In I/O space, a byte access (`size`=0) with `addr[1:0]`=00 runs an 8-bit cycle. The card address is {addr[10:2], 0}, `p_ben`=01 and the write data is {8'h00, wdata[7:0]}.
- R3: In I/O space, a byte access with `addr[1:0]`=01 addresses the odd port {addr[10:2], 1} with `p_ben`=10. The write data is {wdata[15:8], 8'h00}.
- R4: A word access (`size`=2) with `addr[1:0]`=00 runs a single byte cycle with card address bit 0 forced to 1 and `p_ben`=01. The write data is {8'h00, wdata[7:0]}, and wdata[31:8] has no effect.
- R5: A halfword access (`size`=1) with `addr[1:0]`=00 runs a 16-bit cycle with card bit 0 = 0, `p_ben`=11 and data wdata[15:0]. A halfword or word access with `addr[1:0]`≠00, and any access with `size`=3, is illegal.
- R6: In I/O space, when addr[11:5] equals port base[9:3] for base 0x3F8, 0x2F8 or 0x378, the access takes this rule before all other I/O rules. The port is addr[11:2], `p_ben`=01 and the data is on D7:D0. Only a byte access with `addr[1:0]`=00 is legal there.
- R7: In memory space (`space`=1), the card address is {addr[23:19], addr[17:2], b0}. Bit b0 and `p_ben` follow the same size/low-bit rules as R2–R5.
- R8: A memory access with addr[17] ≠ addr[18] is illegal.
- R9: An I/O access outside R6 is illegal if addr[23:11] is nonzero or if addr[1]=1 for a byte access.
- R10: The strobe stays active for WAIT_CYC clocks (default 4). It stays active longer for as long as `p_ready` is low at the end of a strobe clock. `ack` pulses for one clock in the cycle after the strobe ends.
- R11: An illegal access raises `err` for one clock, in the cycle after the one in which the bridge accepts `req`. It produces no strobe and no `ack`.
- R12: Read data is sampled at the end of the strobe and returned with `ack`. A low-lane or special-word read returns {24'h0, p_rdata[7:0]}, an odd-lane byte returns {16'h0, p_rdata[15:8], 8'h00`, and a halfword returns {16'h0, p_rdata}.
- R13: At most one of the four strobes is active at a time. Card address, lane enables and write data stay constant while a strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until ack or err |
| we | input | 1 | 1 = write, 0 = read |
| space | input | 1 | 0 = I/O space, 1 = memory window |
| size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| addr | input | 24 | Processor byte offset in the selected space |
| wdata | input | 32 | Processor write data |
| ack | output | 1 | Access completed |
| err | output | 1 | Access rejected |
| rdata | output | 32 | Processor read data, valid with ack |
| p_addr | output | 22 | Card address |
| p_ben | output | 2 | Lane enables, bit 0 = D7:D0, bit 1 = D15:D8 |
| p_iord | output | 1 | I/O read strobe |
| p_iowr | output | 1 | I/O write strobe |
| p_memrd | output | 1 | Memory read strobe |
| p_memwr | output | 1 | Memory write strobe |
| p_wdata | output | 16 | Peripheral write data |
| p_rdata | input | 16 | Peripheral read data |
| p_ready | input | 1 | Peripheral ready, low extends the strobe |

## Verification
On every cycle the assertions check the following. No more than one strobe is active. Address, lane enables and write data hold steady under a strobe. An acknowledge always comes after a strobe that ran at least the full wait count. An error is a lone pulse with no strobe or acknowledge beside it.

Only the scenarios can show the mapping itself. This covers the port arithmetic, the odd-lane and special-word cases, the port-group priority, the memory scramble, the legality rules, the wait extension under a late ready and where read bytes land. Each of these is compared against values worked out by hand from the requirements.

// File: rtl/isa_lane_pkg.sv
package isa_lane_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      LN_LO   = 2'd0,
      LN_HI   = 2'd1,
      LN_BOTH = 2'd2
   } lane_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_STB  = 2'd1,
      ST_ACK  = 2'd2,
      ST_ERR  = 2'd3
   } cyc_state_e;

   function automatic logic [1:0] lane_enables(lane_e ln);
      case (ln)
         LN_HI:   return 2'b10;
         LN_BOTH: return 2'b11;
         default: return 2'b01;
      endcase
   endfunction

endpackage

// File: rtl/isa_addr_decode.sv
module isa_addr_decode
   import isa_lane_pkg::*;
#(
   parameter int  ADDR_W     = 24,
   parameter int  CARD_W     = 22,
   parameter int  PORT_W     = 10,
   parameter int  MEM_DUP    = 18,
   parameter bit  HAS_GROUPS = 1'b1
) (
   input  logic              space,
   input  logic [1:0]        size,
   input  logic [ADDR_W-1:0] addr,
   output logic              illegal,
   output lane_e             lane,
   output logic [CARD_W-1:0] card
);
   localparam int NGRP  = 3;
   localparam int GTAG  = PORT_W - 3;
   localparam logic [PORT_W-1:0] GRP_BASE [NGRP] = '{
      PORT_W'('h3F8), PORT_W'('h2F8), PORT_W'('h378)};

   logic [NGRP-1:0] grp_match;
   logic            grp_hit;
   logic            a0;
   logic            sz_bad;
   lane_e           sz_lane;

   generate
      if (HAS_GROUPS) begin : g_groups
         for (genvar g = 0; g < NGRP; g++) begin : g_cmp
            assign grp_match[g] =
               (addr[PORT_W+1:5] == GRP_BASE[g][PORT_W-1:3]);
         end
      end else begin : g_nogroups
         assign grp_match = '0;
      end
   endgenerate

   assign grp_hit = !space && (|grp_match);

   always_comb begin
      a0      = 1'b0;
      sz_lane = LN_LO;
      sz_bad  = 1'b0;
      case (size)
         SZ_BYTE: begin
            sz_bad  = addr[1];
            a0      = addr[0];
            sz_lane = addr[0] ? LN_HI : LN_LO;
         end
         SZ_HALF: begin
            sz_bad  = |addr[1:0];
            sz_lane = LN_BOTH;
         end
         SZ_WORD: begin
            sz_bad  = |addr[1:0];
            a0      = 1'b1;
            sz_lane = LN_LO;
         end
         default: sz_bad = 1'b1;
      endcase
   end

   always_comb begin
      if (grp_hit) begin
         lane    = LN_LO;
         illegal = (size != SZ_BYTE) || (|addr[1:0]) || (|addr[ADDR_W-1:PORT_W+2]);
         card    = CARD_W'(addr[PORT_W+1:2]);
      end else if (!space) begin
         lane    = sz_lane;
         illegal = sz_bad || (|addr[ADDR_W-1:PORT_W+1]);
         card    = CARD_W'({addr[PORT_W:2], a0});
      end else begin
         lane    = sz_lane;
         illegal = sz_bad || (addr[MEM_DUP] != addr[MEM_DUP-1]);
         card    = {addr[ADDR_W-1:MEM_DUP+1], addr[MEM_DUP-1:2], a0};
      end
   end

endmodule

// File: rtl/isa_lane_steer.sv
module isa_lane_steer
   import isa_lane_pkg::*;
#(
   parameter int HOST_W = 32,
   parameter int DEV_W  = 16
) (
   input  lane_e             lane_wr,
   input  logic [HOST_W-1:0] host_wdata,
   output logic [DEV_W-1:0]  dev_wdata,
   input  lane_e             lane_rd,
   input  logic [DEV_W-1:0]  dev_rdata,
   output logic [HOST_W-1:0] host_rdata
);
   localparam int BYTE_W = DEV_W / 2;

   logic unused_upper;
   assign unused_upper = ^host_wdata[HOST_W-1:DEV_W];

   always_comb begin
      case (lane_wr)
         LN_HI:   dev_wdata = {host_wdata[DEV_W-1:BYTE_W], {BYTE_W{1'b0}}};
         LN_BOTH: dev_wdata = host_wdata[DEV_W-1:0];
         default: dev_wdata = {{BYTE_W{1'b0}}, host_wdata[BYTE_W-1:0]};
      endcase
   end

   always_comb begin
      case (lane_rd)
         LN_HI:   host_rdata = HOST_W'({dev_rdata[DEV_W-1:BYTE_W], {BYTE_W{1'b0}}});
         LN_BOTH: host_rdata = HOST_W'(dev_rdata);
         default: host_rdata = HOST_W'(dev_rdata[BYTE_W-1:0]);
      endcase
   end

endmodule

// File: rtl/isa_cycle_fsm.sv
module isa_cycle_fsm
   import isa_lane_pkg::*;
#(
   parameter int WAIT_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic illegal,
   input  logic ready,
   output logic cap,
   output logic stb,
   output logic fin,
   output logic ack,
   output logic err
);
   localparam int CNT_W = $clog2(WAIT_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(WAIT_CYC);

   cyc_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;

   assign cap = (state_q == ST_IDLE) && req;
   assign stb = (state_q == ST_STB);
   assign fin = stb && (cnt_q == LAST) && ready;
   assign ack = (state_q == ST_ACK);
   assign err = (state_q == ST_ERR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (req) state_q <= illegal ? ST_ERR : ST_STB;
            end
            ST_STB: begin
               if (fin)                state_q <= ST_ACK;
               else if (cnt_q != LAST) cnt_q   <= cnt_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // independent strobe-length counter for the checks below
   logic [CNT_W-1:0] run_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                     run_q <= '0;
      else if (cap)                   run_q <= '0;
      else if (stb && run_q != FULL)  run_q <= run_q + 1'b1;
   end

   a_r10_full_wait: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> run_q == FULL);
   a_r10_ack_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(stb));
   a_r11_err_single: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);
   a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !stb && !ack && run_q == '0);

endmodule

// File: rtl/isa_lane_bridge.sv
module isa_lane_bridge
   import isa_lane_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int HOST_W     = 32,
   parameter int DEV_W      = 16,
   parameter int PORT_W     = 10,
   parameter int WAIT_CYC   = 4,
   parameter bit HAS_GROUPS = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req,
   input  logic                  we,
   input  logic                  space,
   input  logic [1:0]            size,
   input  logic [ADDR_W-1:0]     addr,
   input  logic [HOST_W-1:0]     wdata,
   output logic                  ack,
   output logic                  err,
   output logic [HOST_W-1:0]     rdata,
   output logic [ADDR_W-3:0]     p_addr,
   output logic [1:0]            p_ben,
   output logic                  p_iord,
   output logic                  p_iowr,
   output logic                  p_memrd,
   output logic                  p_memwr,
   output logic [DEV_W-1:0]      p_wdata,
   input  logic [DEV_W-1:0]      p_rdata,
   input  logic                  p_ready
);
   localparam int CARD_W  = ADDR_W - 2;
   localparam int MEM_DUP = 18;

   generate
      if (ADDR_W != 24)   begin : g_chk_aw   $error("ADDR_W must be 24"); end
      if (HOST_W < 2*DEV_W) begin : g_chk_hw $error("HOST_W too narrow"); end
      if (DEV_W != 16)    begin : g_chk_dw   $error("DEV_W must be 16"); end
      if (PORT_W != 10)   begin : g_chk_pw   $error("PORT_W must be 10"); end
      if (WAIT_CYC < 1)   begin : g_chk_wc   $error("WAIT_CYC must be >= 1"); end
   endgenerate

   logic              dec_illegal;
   lane_e             dec_lane;
   logic [CARD_W-1:0] dec_card;
   logic [DEV_W-1:0]  steer_wdata;
   logic [HOST_W-1:0] steer_rdata;
   logic              cap, stb, fin;

   lane_e             lane_q;
   logic              mem_q, wr_q;
   logic [CARD_W-1:0] card_q;
   logic [DEV_W-1:0]  wdat_q;
   logic [HOST_W-1:0] rdat_q;

   isa_addr_decode #(
      .ADDR_W(ADDR_W), .CARD_W(CARD_W), .PORT_W(PORT_W),
      .MEM_DUP(MEM_DUP), .HAS_GROUPS(HAS_GROUPS)
   ) i_decode (
      .space(space), .size(size), .addr(addr),
      .illegal(dec_illegal), .lane(dec_lane), .card(dec_card)
   );

   isa_lane_steer #(.HOST_W(HOST_W), .DEV_W(DEV_W)) i_steer (
      .lane_wr(dec_lane), .host_wdata(wdata), .dev_wdata(steer_wdata),
      .lane_rd(lane_q), .dev_rdata(p_rdata), .host_rdata(steer_rdata)
   );

   isa_cycle_fsm #(.WAIT_CYC(WAIT_CYC)) i_fsm (
      .clk(clk), .rst_n(rst_n), .req(req), .illegal(dec_illegal),
      .ready(p_ready), .cap(cap), .stb(stb), .fin(fin), .ack(ack), .err(err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lane_q <= LN_LO;
         mem_q  <= 1'b0;
         wr_q   <= 1'b0;
         card_q <= '0;
         wdat_q <= '0;
         rdat_q <= '0;
      end else begin
         if (cap) begin
            lane_q <= dec_lane;
            mem_q  <= space;
            wr_q   <= we;
            card_q <= dec_card;
            wdat_q <= steer_wdata;
         end
         if (fin && !wr_q) rdat_q <= steer_rdata;
      end
   end

   assign p_addr  = card_q;
   assign p_ben   = stb ? lane_enables(lane_q) : 2'b00;
   assign p_iord  = stb && !mem_q && !wr_q;
   assign p_iowr  = stb && !mem_q &&  wr_q;
   assign p_memrd = stb &&  mem_q && !wr_q;
   assign p_memwr = stb &&  mem_q &&  wr_q;
   assign p_wdata = wdat_q;
   assign rdata   = rdat_q;

   a_r13_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({p_iord, p_iowr, p_memrd, p_memwr}));
   a_r13_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && $past(stb)) |-> ($stable(p_addr) && $stable(p_ben) && $stable(p_wdata)));
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $past(!rst_n) |-> !(p_iord || p_iowr || p_memrd || p_memwr || ack || err));
   a_r13_ben_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (p_ben != 2'b00) == (p_iord || p_iowr || p_memrd || p_memwr));

endmodule

// File: tb/test_isa_lane_bridge.sv
module test_isa_lane_bridge;
   localparam int WAIT = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0, space = 1'b0;
   logic [1:0]  size = 2'd0;
   logic [23:0] addr = '0;
   logic [31:0] wdata = '0;
   logic        ack, err;
   logic [31:0] rdata;
   logic [21:0] p_addr;
   logic [1:0]  p_ben;
   logic        p_iord, p_iowr, p_memrd, p_memwr;
   logic [15:0] p_wdata;
   logic [15:0] p_rdata = '0;
   logic        p_ready = 1'b1;

   always #4 clk = ~clk;

   isa_lane_bridge i_isa_lane_bridge (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .space(space),
      .size(size), .addr(addr), .wdata(wdata), .ack(ack), .err(err),
      .rdata(rdata), .p_addr(p_addr), .p_ben(p_ben), .p_iord(p_iord),
      .p_iowr(p_iowr), .p_memrd(p_memrd), .p_memwr(p_memwr),
      .p_wdata(p_wdata), .p_rdata(p_rdata), .p_ready(p_ready));

   typedef struct {
      bit          is_err;
      bit          wr;
      int          kind;
      logic [21:0] pa;
      logic [1:0]  ben;
      logic [15:0] pw;
      logic [31:0] rd;
      int          slen;
      string       tag;
   } exp_t;

   exp_t sb_q[$];
   int   n_chk = 0, n_err = 0;
   int   cur_hold = 0;
   bit   done = 0;

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // driver: kind 0 iord, 1 iowr, 2 memrd, 3 memwr
   task automatic acc(bit sp, bit w, logic [1:0] sz, logic [23:0] a, logic [31:0] wd,
                      logic [15:0] prd, int hold, bit e_err, int kind,
                      logic [21:0] pa, logic [1:0] ben, logic [15:0] pw,
                      logic [31:0] rd, string tag);
      exp_t e;
      e.is_err = e_err; e.wr = w; e.kind = kind; e.pa = pa; e.ben = ben;
      e.pw = pw; e.rd = rd; e.tag = tag;
      e.slen = (hold + 1 > WAIT) ? hold + 1 : WAIT;
      sb_q.push_back(e);
      cur_hold = hold;
      @(posedge clk); #1;
      space = sp; we = w; size = sz; addr = a; wdata = wd; p_rdata = prd; req = 1'b1;
      forever begin
         @(negedge clk);
         if (ack || err) break;
      end
      @(posedge clk); #1;
      req = 1'b0;
      @(posedge clk); #1;
   endtask

   // monitor / scoreboard
   initial begin
      int lat = 0, slen = 0, okind = -1;
      bit in_stb = 0, saw = 0;
      logic [21:0] opa; logic [1:0] oben; logic [15:0] opw;
      exp_t e;
      forever begin
         @(negedge clk);
         if (req) lat++; else lat = 0;
         if (p_iord | p_iowr | p_memrd | p_memwr) begin
            if (!in_stb) begin
               slen = 0; opa = p_addr; oben = p_ben; opw = p_wdata;
               okind = p_iord ? 0 : p_iowr ? 1 : p_memrd ? 2 : 3;
            end
            slen++; in_stb = 1; saw = 1;
            p_ready = (slen - 1 >= cur_hold);
         end else begin
            in_stb = 0;
            p_ready = 1'b1;
         end
         if ((ack || err) && sb_q.size() > 0) begin
            e = sb_q.pop_front();
            if (e.is_err) begin
               chk(err && !ack, e.tag, "err response", {30'b0, ack, err}, 32'h1);
               chk(lat == 2, "R11", "err latency", lat, 2);
               chk(!saw, "R11", "strobe on rejected access", saw, 0);
            end else begin
               chk(ack && !err, e.tag, "ack response", {30'b0, ack, err}, 32'h2);
               chk(saw && okind == e.kind, e.tag, "strobe kind", okind, e.kind);
               chk(opa == e.pa, e.tag, "card address", opa, e.pa);
               chk(oben == e.ben, e.tag, "lane enables", oben, e.ben);
               chk(slen == e.slen, "R10", "strobe length", slen, e.slen);
               chk(lat == e.slen + 2, "R10", "ack latency", lat, e.slen + 2);
               if (e.wr) chk(opw == e.pw, e.tag, "write data", opw, e.pw);
               else      chk(rdata == e.rd, "R12", "read data", rdata, e.rd);
            end
            saw = 0;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      localparam logic [31:0] WD = 32'h11223344;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk({p_iord, p_iowr, p_memrd, p_memwr, ack, err} == 6'b0 && p_ben == 2'b00,
          "R1", "outputs in reset", {p_iord, p_iowr, p_memrd, p_memwr, ack, err}, 0);
      @(posedge clk); #1; rst_n = 1'b1;
      @(negedge clk);
      chk({p_iord, p_iowr, p_memrd, p_memwr, ack, err} == 6'b0,
          "R1", "outputs after reset", {p_iord, p_iowr, p_memrd, p_memwr, ack, err}, 0);

      // R2 even byte
      acc(0,1,2'd0,24'h000120,WD,16'h0,0, 0,1,22'h090,2'b01,16'h0044,0,"R2");
      acc(0,0,2'd0,24'h000130,WD,16'h9A5B,0, 0,0,22'h098,2'b01,0,32'h5B,"R2");
      // R3 odd byte, high lane
      acc(0,1,2'd0,24'h000121,WD,16'h0,0, 0,1,22'h091,2'b10,16'h3300,0,"R3");
      acc(0,0,2'd0,24'h000125,WD,16'hA55A,0, 0,0,22'h093,2'b10,0,32'h0000A500,"R3");
      // R4 special word cycle
      acc(0,1,2'd2,24'h000124,WD,16'h0,0, 0,1,22'h093,2'b01,16'h0044,0,"R4");
      acc(0,0,2'd2,24'h000124,WD,16'hBEEF,0, 0,0,22'h093,2'b01,0,32'h000000EF,"R4");
      // R5 halfword and its illegal forms
      acc(0,1,2'd1,24'h000200,WD,16'h0,0, 0,1,22'h100,2'b11,16'h3344,0,"R5");
      acc(0,0,2'd1,24'h000201,WD,16'h0,0, 1,0,0,0,0,0,"R5");
      acc(0,1,2'd2,24'h000206,WD,16'h0,0, 1,0,0,0,0,0,"R5");
      acc(0,1,2'd3,24'h000200,WD,16'h0,0, 1,0,0,0,0,0,"R5");
      // R10 ready held low extends strobe
      acc(0,0,2'd1,24'h000204,WD,16'hC3D4,6, 0,0,22'h102,2'b11,0,32'h0000C3D4,"R10");
      // R9 I/O range and byte offset bit 1
      acc(0,1,2'd0,24'h000122,WD,16'h0,0, 1,0,0,0,0,0,"R9");
      acc(0,1,2'd0,24'h000800,WD,16'h0,0, 1,0,0,0,0,0,"R9");
      // R6 port groups
      acc(0,1,2'd0,24'h000FE4,WD,16'h0,0, 0,1,22'h3F9,2'b01,16'h0044,0,"R6");
      acc(0,0,2'd0,24'h000BE0,WD,16'h1234,0, 0,0,22'h2F8,2'b01,0,32'h34,"R6");
      acc(0,1,2'd0,24'h000DFC,WD,16'h0,0, 0,1,22'h37F,2'b01,16'h0044,0,"R6");
      acc(0,1,2'd1,24'h000FE4,WD,16'h0,0, 1,0,0,0,0,0,"R6");
      acc(0,1,2'd0,24'h000FE5,WD,16'h0,0, 1,0,0,0,0,0,"R6");
      acc(0,1,2'd2,24'h000FE4,WD,16'h0,0, 1,0,0,0,0,0,"R6");
      // R7 memory window
      acc(1,1,2'd0,24'h060004,WD,16'h0,0, 0,3,22'h010002,2'b01,16'h0044,0,"R7");
      acc(1,0,2'd1,24'hF80008,WD,16'h5566,0, 0,2,22'h3E0004,2'b11,0,32'h5566,"R7");
      acc(1,0,2'd0,24'h000001,WD,16'h7788,0, 0,2,22'h000001,2'b10,0,32'h7700,"R7");
      acc(1,1,2'd2,24'h00000C,WD,16'h0,0, 0,3,22'h000007,2'b01,16'h0044,0,"R7");
      // R8 memory legality
      acc(1,1,2'd0,24'h0A0004,WD,16'h0,0, 1,0,0,0,0,0,"R8");
      acc(1,0,2'd0,24'h040000,WD,16'h0,0, 1,0,0,0,0,0,"R8");

      repeat (4) @(negedge clk);
      chk(sb_q.size() == 0, "R13", "pending responses", sb_q.size(), 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule